// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Cache Lookup

This block is the lookup half of a direct-mapped 64 KB cache with 32-byte lines, placed between a load/store address source and a separate address translation unit. A request brings a 32-bit virtual address. In the cycle it is accepted, the tag and data arrays are read using virtual address bits 15 to 5 as the line index. Translation runs in parallel and returns the physical page number in the following cycle. The stored physical tag is then compared against it, giving a hit flag and the addressed 32-bit word.

Pages are 16 KB, so the page offset is 14 bits and the page number is 18 bits. The line index reaches two bits above the page offset. One physical block can therefore occupy up to four lines, one for each value of virtual bits 15:14 (the line's "colour"). Each line stores all 18 physical page bits: the 16-bit tag (physical bits 31:16) and the two colour bits (physical bits 15:14). A hit needs all 18 to match. On a miss, the block also reports whether one of the three other lines of the same colour group already holds the same physical block. This lets the surrounding logic find a duplicate copy. A fill port installs a line after a miss, and a flush input invalidates the whole cache in one cycle.

The controller has three states. ST_IDLE means no lookup is pending. ST_TAG is the first compare cycle after a request is accepted. ST_HOLD means translation was not ready in the previous compare cycle. The transitions are:
- ST_IDLE to ST_TAG when a request arrives.
- ST_TAG or ST_HOLD to ST_HOLD while translation is not ready.
- ST_TAG or ST_HOLD to ST_TAG when translation is ready and a new request arrives in the same cycle.
- ST_TAG or ST_HOLD to ST_IDLE when translation is ready and no new request arrives.

Top module: `vipt_lookup`

## Requirements
- R1: After reset every line is invalid, req_ready is 1, resp_valid is 0, and any lookup reports a miss.
- R2: A request is accepted when req_valid and req_ready are both 1 at a clock edge. The line index is req_vaddr[15:5], captured at that edge. If xlat_ready is 1 in the next cycle, that cycle shows resp_valid = 1 with the result. Back-to-back requests are accepted every cycle.
- R3: resp_hit is 1 only if the indexed line is valid and its stored 18 physical page bits equal xlat_ppn. The stored bits are physical address bits 31:16 followed by bits 15:14.
- R4: On a hit, resp_data is word req_vaddr[4:2] of the line, where word w occupies fill_line bits 32w+31 to 32w. On a miss, resp_data is 0.
- R5: While a lookup waits in the compare stage with xlat_ready at 0, resp_valid and req_ready are 0 and later changes of req_vaddr have no effect. The result is produced in the first cycle xlat_ready is 1, using the xlat_ppn value of that cycle.
- R6: A fill writes fill_line and fill_ppn into line fill_vaddr[15:5] and marks the line valid. A later lookup of that index with the same page number hits.
- R7: A flush pulse invalidates every line in one cycle. A lookup pending in the compare stage during the flush reports a miss. When flush and fill occur in the same cycle, the flush wins.
- R8: On a miss, resp_dup is 1 exactly when one of the three other lines that share req_vaddr[13:5] is valid and holds xlat_ppn. On a hit, resp_dup is 0.
- R9: One physical block filled under two virtual addresses that differ only in bits 15:14 occupies two lines. Each line hits independently with its own data.
- R10: A lookup accepted in the same cycle as a fill to its index sees the line's contents from before the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all lines |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup can be accepted this cycle |
| req_vaddr | input | 32 | Virtual address of the lookup |
| xlat_ready | input | 1 | Translation result present |
| xlat_ppn | input | 18 | Translated physical page number |
| fill_valid | input | 1 | Install a line |
| fill_vaddr | input | 32 | Virtual address selecting the line to fill |
| fill_ppn | input | 18 | Physical page number stored with the filled line |
| fill_line | input | 256 | Block contents, word 0 in the low bits |
| resp_valid | output | 1 | Lookup result present |
| resp_hit | output | 1 | Lookup hit |
| resp_dup | output | 1 | Miss, but a sibling line holds the same physical block |
| resp_data | output | 32 | Addressed word on a hit, else 0 |

## Verification
Random lookups and fills draw from a small pool of virtual pages, physical pages and low index bits. This keeps hits, tag mismatches, colour mismatches and duplicate copies all frequent, and separates a 16-bit compare from an 18-bit compare. Directed cases cover translation stalls while req_vaddr changes, and a flush arriving during a stall. They also cover a fill and a lookup to the same index in the same cycle (old versus new contents) and a flush together with a fill (which one wins). Synonym cases place one physical block in two colours and check that each line returns its own data. They also check that the duplicate flag tracks sibling lines and never the line that was looked up.

// File: rtl/vipt_pkg.sv
package vipt_pkg;

    // Compare-stage controller states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,  // nothing pending
        ST_TAG  = 2'd1,  // first compare cycle after accept
        ST_HOLD = 2'd2   // compare stalled on translation
    } vipt_state_e;

endpackage

// File: rtl/vipt_tag_store.sv
module vipt_tag_store #(
    parameter int IDX_W   = 11,
    parameter int COLOR_W = 2,
    parameter int PPN_W   = 18
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush,
    input  logic                 rd_en,
    input  logic [IDX_W-COLOR_W-1:0] rd_low,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [PPN_W-1:0]     wr_ppn,
    output logic                 snap_v   [1<<COLOR_W],
    output logic [PPN_W-1:0]     snap_ppn [1<<COLOR_W]
);
    localparam int LINES   = 1 << IDX_W;
    localparam int N_ALIAS = 1 << COLOR_W;

    logic [LINES-1:0] vbits;
    logic [PPN_W-1:0] tags [LINES];
    logic [IDX_W-1:0] alias_idx [N_ALIAS];

    // Every line of the colour group sharing the low index bits
    for (genvar k = 0; k < N_ALIAS; k++) begin : g_alias
        localparam logic [COLOR_W-1:0] KC = COLOR_W'(k);
        assign alias_idx[k] = {KC, rd_low};
    end

    // Valid bits: reset and flush clear, fill sets; flush beats fill
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            vbits <= '0;
        end else if (wr_en) begin
            vbits[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tags[wr_idx] <= wr_ppn;
        end
    end

    // Snapshot read: old contents on a same-cycle write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < N_ALIAS; k++) begin
                snap_v[k]   <= 1'b0;
                snap_ppn[k] <= '0;
            end
        end else begin
            for (int k = 0; k < N_ALIAS; k++) begin
                if (flush) begin
                    snap_v[k] <= 1'b0;
                end else if (rd_en) begin
                    snap_v[k] <= vbits[alias_idx[k]];
                end
                if (rd_en) begin
                    snap_ppn[k] <= tags[alias_idx[k]];
                end
            end
        end
    end

    // R7: a flush leaves no line valid in the next cycle
    a_r7_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (vbits == '0));

    // R6: a fill without flush leaves its line valid
    a_r6_fill_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !flush) |=> vbits[$past(wr_idx)]);

endmodule

// File: rtl/vipt_data_store.sv
module vipt_data_store #(
    parameter int IDX_W     = 11,
    parameter int LINE_BITS = 256,
    parameter int WORD_W    = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_en,
    input  logic [IDX_W-1:0]     rd_idx,
    input  logic [$clog2(LINE_BITS/WORD_W)-1:0] rd_wsel,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [LINE_BITS-1:0] wr_line,
    output logic [WORD_W-1:0]    rd_word
);
    localparam int LINES = 1 << IDX_W;

    logic [LINE_BITS-1:0] mem [LINES];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_line;
        end
    end

    // Word picked at read time so only one word is staged
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_word <= '0;
        end else if (rd_en) begin
            rd_word <= mem[rd_idx][rd_wsel*WORD_W +: WORD_W];
        end
    end

endmodule

// File: rtl/vipt_ctrl.sv
module vipt_ctrl
    import vipt_pkg::*;
#(
    parameter int COLOR_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [COLOR_W-1:0] req_color,
    input  logic               xlat_ready,
    output logic               req_ready,
    output logic               accept,
    output logic               resp_valid,
    output logic [COLOR_W-1:0] s2_color
);
    vipt_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_TAG;
            ST_TAG, ST_HOLD: begin
                if (!xlat_ready)     state_d = ST_HOLD;
                else if (req_valid)  state_d = ST_TAG;
                else                 state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        req_ready  = 1'b0;
        resp_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_TAG, ST_HOLD: begin
                req_ready  = xlat_ready;
                resp_valid = xlat_ready;
            end
            default: req_ready = 1'b0;
        endcase
        accept = req_valid && req_ready;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      s2_color <= '0;
        else if (accept) s2_color <= req_color;
    end

    // R5: a stalled compare keeps its captured request
    a_r5_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && !xlat_ready) |=> $stable(s2_color));

    // R2: a result is always preceded by an accept or a stall
    a_r2_resp_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> ($past(accept) || $past(state_q == ST_HOLD || state_q == ST_TAG)));

endmodule

// File: rtl/vipt_lookup.sv
module vipt_lookup #(
    parameter int VA_W   = 32,
    parameter int PA_W   = 32,
    parameter int PG_W   = 14,
    parameter int BLK_W  = 5,
    parameter int IDX_W  = 11,
    parameter int WORD_W = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic [VA_W-1:0]              req_vaddr,
    input  logic                         xlat_ready,
    input  logic [PA_W-PG_W-1:0]         xlat_ppn,
    input  logic                         fill_valid,
    input  logic [VA_W-1:0]              fill_vaddr,
    input  logic [PA_W-PG_W-1:0]         fill_ppn,
    input  logic [(8<<BLK_W)-1:0]        fill_line,
    output logic                         resp_valid,
    output logic                         resp_hit,
    output logic                         resp_dup,
    output logic [WORD_W-1:0]            resp_data
);
    localparam int PPN_W     = PA_W - PG_W;
    localparam int COLOR_W   = IDX_W + BLK_W - PG_W;
    localparam int N_ALIAS   = 1 << COLOR_W;
    localparam int LOW_W     = IDX_W - COLOR_W;
    localparam int LINE_BITS = 8 << BLK_W;
    localparam int BYTE_SEL  = $clog2(WORD_W / 8);
    localparam int WSEL_W    = BLK_W - BYTE_SEL;

    logic               accept;
    logic [COLOR_W-1:0] s2_color;
    logic               snap_v   [N_ALIAS];
    logic [PPN_W-1:0]   snap_ppn [N_ALIAS];
    logic [WORD_W-1:0]  rd_word;
    logic               own_hit, sib_match;

    vipt_ctrl #(.COLOR_W(COLOR_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_color  (req_vaddr[PG_W +: COLOR_W]),
        .xlat_ready (xlat_ready),
        .req_ready  (req_ready),
        .accept     (accept),
        .resp_valid (resp_valid),
        .s2_color   (s2_color)
    );

    vipt_tag_store #(.IDX_W(IDX_W), .COLOR_W(COLOR_W), .PPN_W(PPN_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .rd_en    (accept),
        .rd_low   (req_vaddr[BLK_W +: LOW_W]),
        .wr_en    (fill_valid),
        .wr_idx   (fill_vaddr[BLK_W +: IDX_W]),
        .wr_ppn   (fill_ppn),
        .snap_v   (snap_v),
        .snap_ppn (snap_ppn)
    );

    vipt_data_store #(.IDX_W(IDX_W), .LINE_BITS(LINE_BITS), .WORD_W(WORD_W)) u_data (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (accept),
        .rd_idx  (req_vaddr[BLK_W +: IDX_W]),
        .rd_wsel (req_vaddr[BYTE_SEL +: WSEL_W]),
        .wr_en   (fill_valid),
        .wr_idx  (fill_vaddr[BLK_W +: IDX_W]),
        .wr_line (fill_line),
        .rd_word (rd_word)
    );

    // Physical compare once translation has returned
    always_comb begin
        own_hit   = snap_v[s2_color] && (snap_ppn[s2_color] == xlat_ppn);
        sib_match = 1'b0;
        for (int k = 0; k < N_ALIAS; k++) begin
            if ((COLOR_W'(k) != s2_color) && snap_v[k] && (snap_ppn[k] == xlat_ppn)) begin
                sib_match = 1'b1;
            end
        end
        resp_hit  = resp_valid && own_hit;
        resp_dup  = resp_valid && !own_hit && sib_match;
        resp_data = resp_hit ? rd_word : '0;
    end

    logic unused_bits;
    assign unused_bits = ^{req_vaddr[VA_W-1:PG_W+COLOR_W], req_vaddr[BYTE_SEL-1:0],
                           fill_vaddr[VA_W-1:BLK_W+IDX_W], fill_vaddr[BLK_W-1:0]};

    // R8: the duplicate flag never accompanies a hit
    a_r8_dup_only_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
        resp_hit |-> !resp_dup);

    // R4: no data word leaves on a miss
    a_r4_quiet_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_hit) |-> (resp_data == '0));

endmodule

// File: tb/vipt_lookup_tb.sv
`timescale 1ns/1ps
module vipt_lookup_tb;
    localparam int LINES = 2048;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         flush = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [31:0]  req_vaddr = '0;
    logic         xlat_ready = 1'b0;
    logic [17:0]  xlat_ppn = '0;
    logic         fill_valid = 1'b0;
    logic [31:0]  fill_vaddr = '0;
    logic [17:0]  fill_ppn = '0;
    logic [255:0] fill_line = '0;
    logic         resp_valid, resp_hit, resp_dup;
    logic [31:0]  resp_data;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    bit           m_v   [LINES];
    logic [17:0]  m_ppn [LINES];
    logic [255:0] m_line[LINES];

    vipt_lookup u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .xlat_ready(xlat_ready), .xlat_ppn(xlat_ppn),
        .fill_valid(fill_valid), .fill_vaddr(fill_vaddr), .fill_ppn(fill_ppn),
        .fill_line(fill_line),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_dup(resp_dup),
        .resp_data(resp_data)
    );

    always #4 clk = ~clk;

    function automatic bit exp_hit(input logic [31:0] va, input logic [17:0] p);
        return m_v[va[15:5]] && (m_ppn[va[15:5]] == p);
    endfunction

    function automatic bit exp_dup(input logic [31:0] va, input logic [17:0] p);
        bit d = 1'b0;
        if (exp_hit(va, p)) return 1'b0;
        for (int k = 0; k < 4; k++) begin
            logic [10:0] ix = {k[1:0], va[13:5]};
            if (k[1:0] != va[15:14] && m_v[ix] && m_ppn[ix] == p) d = 1'b1;
        end
        return d;
    endfunction

    function automatic logic [31:0] exp_data(input logic [31:0] va, input logic [17:0] p);
        if (!exp_hit(va, p)) return 32'h0;
        return m_line[va[15:5]][va[4:2]*32 +: 32];
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_flush();
        for (int i = 0; i < LINES; i++) m_v[i] = 1'b0;
    endtask

    task automatic do_fill(input logic [31:0] va, input logic [17:0] p, input logic [255:0] ln);
        @(negedge clk);
        fill_valid = 1'b1; fill_vaddr = va; fill_ppn = p; fill_line = ln;
        @(posedge clk); #1;
        fill_valid = 1'b0;
        m_v[va[15:5]] = 1'b1; m_ppn[va[15:5]] = p; m_line[va[15:5]] = ln;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(posedge clk); #1;
        flush = 1'b0;
        model_flush();
    endtask

    // Full lookup; expected result from the model at the time of sampling
    task automatic do_lookup(input string req, input logic [31:0] va, input logic [17:0] p);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; xlat_ready = 1'b1; xlat_ppn = p;
        @(posedge clk); #1;
        req_valid = 1'b0;
        @(negedge clk);
        chk({req, " valid"}, {63'h0, resp_valid}, 64'h1);
        chk({req, " hit"},   {63'h0, resp_hit},   {63'h0, exp_hit(va, p)});
        chk({req, " dup"},   {63'h0, resp_dup},   {63'h0, exp_dup(va, p)});
        chk({req, " data"},  {32'h0, resp_data},  {32'h0, exp_data(va, p)});
        @(posedge clk); #1;
    endtask

    function automatic logic [255:0] rnd_line();
        logic [255:0] l;
        for (int w = 0; w < 8; w++) l[w*32 +: 32] = $urandom;
        return l;
    endfunction

    initial begin
        #(8 * 150000);
        fails++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
        end
        $finish;
    end

    initial begin
        logic [31:0]  va, va2;
        logic [17:0]  pp;
        logic [255:0] ln;
        int           seed_sink;
        seed_sink = $urandom(32'd2718);
        model_flush();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        chk("R1 req_ready", {63'h0, req_ready}, 64'h1);
        chk("R1 resp_valid", {63'h0, resp_valid}, 64'h0);
        do_lookup("R1 cold miss", 32'h1234_5678, 18'h048D1);

        // R6/R3/R4: fill then hit, each word
        ln = rnd_line();
        do_fill(32'h0000_4020, 18'h2A_AA9, ln);
        for (int w = 0; w < 8; w++) begin
            do_lookup("R4 word select", 32'h0000_4020 | (w << 2), 18'h2A_AA9);
        end
        do_lookup("R6 filled line hit", 32'h7777_4020, 18'h2A_AA9);
        // R3: tag matches but colour bits differ -> miss
        do_lookup("R3 colour mismatch", 32'h0000_4020, 18'h2A_AA8);
        // R3: colour matches, one upper tag bit differs -> miss
        do_lookup("R3 tag mismatch", 32'h0000_4020, 18'h3A_AA9);

        // R8/R9: synonym in another colour
        do_lookup("R8 sibling duplicate", 32'h0000_C020, 18'h2A_AA9);
        do_lookup("R8 no duplicate", 32'h0000_8020, 18'h11111);
        ln = rnd_line();
        do_fill(32'h0000_C020, 18'h2A_AA9, ln);
        do_lookup("R9 synonym line A", 32'h0000_4024, 18'h2A_AA9);
        do_lookup("R9 synonym line B", 32'h0000_C024, 18'h2A_AA9);

        // R5: stall with changing request address
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = 32'h0000_4028; xlat_ready = 1'b0; xlat_ppn = 18'h0;
        @(posedge clk); #1;
        req_valid = 1'b0;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            req_vaddr = 32'h0000_0000 + (c << 5);
            #1;
            chk("R5 stalled resp_valid", {63'h0, resp_valid}, 64'h0);
            chk("R5 stalled req_ready", {63'h0, req_ready}, 64'h0);
        end
        @(negedge clk);
        xlat_ready = 1'b1; xlat_ppn = 18'h2A_AA9;
        #1;
        chk("R5 release valid", {63'h0, resp_valid}, 64'h1);
        chk("R5 release hit", {63'h0, resp_hit}, 64'h1);
        chk("R5 release data", {32'h0, resp_data}, {32'h0, exp_data(32'h0000_4028, 18'h2A_AA9)});
        @(posedge clk); #1;

        // R2: back-to-back requests, one result per cycle
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = 32'h0000_4020; xlat_ready = 1'b1; xlat_ppn = 18'h2A_AA9;
        @(posedge clk); #1;
        req_vaddr = 32'h0000_C03C;
        @(negedge clk);
        chk("R2 first result", {32'h0, resp_data}, {32'h0, exp_data(32'h0000_4020, 18'h2A_AA9)});
        chk("R2 accept while responding", {63'h0, req_ready}, 64'h1);
        @(posedge clk); #1;
        req_valid = 1'b0;
        @(negedge clk);
        chk("R2 second result valid", {63'h0, resp_valid}, 64'h1);
        chk("R2 second result", {32'h0, resp_data}, {32'h0, exp_data(32'h0000_C03C, 18'h2A_AA9)});
        @(posedge clk); #1;

        // R7: flush during a stalled compare
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = 32'h0000_4020; xlat_ready = 1'b0;
        @(posedge clk); #1;
        req_valid = 1'b0;
        @(negedge clk);
        flush = 1'b1;
        @(posedge clk); #1;
        flush = 1'b0;
        model_flush();
        @(negedge clk);
        xlat_ready = 1'b1; xlat_ppn = 18'h2A_AA9;
        #1;
        chk("R7 pending lookup misses", {63'h0, resp_hit}, 64'h0);
        chk("R7 pending lookup no dup", {63'h0, resp_dup}, 64'h0);
        @(posedge clk); #1;
        do_lookup("R7 flushed line A", 32'h0000_4020, 18'h2A_AA9);
        do_lookup("R7 flushed line B", 32'h0000_C020, 18'h2A_AA9);

        // R7: flush and fill in the same cycle
        @(negedge clk);
        flush = 1'b1; fill_valid = 1'b1; fill_vaddr = 32'h0000_0100;
        fill_ppn = 18'h00055; fill_line = rnd_line();
        @(posedge clk); #1;
        flush = 1'b0; fill_valid = 1'b0;
        model_flush();
        do_lookup("R7 flush beats fill", 32'h0000_0100, 18'h00055);

        // R10: lookup and fill to one index in the same cycle
        ln = rnd_line();
        @(negedge clk);
        fill_valid = 1'b1; fill_vaddr = 32'h0000_0200; fill_ppn = 18'h00077; fill_line = ln;
        req_valid = 1'b1; req_vaddr = 32'h0000_0204; xlat_ready = 1'b1; xlat_ppn = 18'h00077;
        @(posedge clk); #1;
        fill_valid = 1'b0; req_valid = 1'b0;
        @(negedge clk);
        chk("R10 same-cycle sees old", {63'h0, resp_hit}, 64'h0);
        @(posedge clk); #1;
        m_v[11'h010] = 1'b1; m_ppn[11'h010] = 18'h00077; m_line[11'h010] = ln;
        do_lookup("R10 later sees new", 32'h0000_0204, 18'h00077);

        // Random mix over small pools
        for (int n = 0; n < 400; n++) begin
            int op = $urandom_range(0, 9);
            va = {4'h0, 10'h0, 2'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
                  7'h0, 2'($urandom_range(0, 3)), 3'($urandom_range(0, 7)), 2'b00};
            pp = {14'($urandom_range(0, 2)), 2'b00, 2'($urandom_range(0, 3))};
            if (op < 4) begin
                do_fill(va, pp, rnd_line());
            end else if (op == 9 && $urandom_range(0, 3) == 0) begin
                do_flush();
            end else begin
                va2 = va;
                do_lookup("R3 random lookup", va2, pp);
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
        end
        $finish;
    end
endmodule